// File: doc/BRIEF.md
# Dual-Modulus Programmable Feedback Divider

This block is the programmable feedback divider of a phase-locked-loop synthesiser that runs through an external prescaler able to divide by 40 or by 41. It counts the prescaler's output pulses and drives the modulus-control line so that the prescaler divides by 41 for part of each division cycle and by 40 for the rest. It emits one output pulse per complete cycle. The total ratio, counted in prescaler input clocks, is set by a 14-bit divide word. The word splits into a 6-bit swallow count A and an 8-bit main count M.

The divide word does not arrive in parallel. The block runs its own fragment sequencer and announces which fragment it wants on a 2-bit select output. It samples a 4-bit data input at the end of each select slot. One transfer is four slots: three full nibbles, then a 2-bit remainder. Two control inputs stop a completed transfer from being stored, or halt the sequencer altogether. A shift input moves the whole reachable span up by 5120. A stored word takes effect only when a division cycle ends, so a transfer in progress never disturbs the cycle being counted.

Top module: `dmd_prog_divider`

## Requirements
- R1: With shift_n high, each division cycle spans exactly 40*(M+40)+A input clocks, counted between rising edges of div_pulse. The divide word carries A in bits 5:0 and M in bits 13:6, so the span runs from 1600 to 11839.
- R2: With shift_n low when a cycle begins, that cycle spans 40*(M+168)+A input clocks, which is 5120 more than with shift_n high, giving 6720 to 16959.
- R3: A swallow count above 39 acts as 39.
- R4: mod_ctl (1 = divide by 41) is high for exactly the first A pre_tick pulses after a cycle boundary and low for the rest of the cycle. It changes only on a clock that follows a pre_tick, and it can only rise in the cycle in which div_pulse is high.
- R5: A cycle ends on the pre_tick that completes M+base prescaler outputs. div_pulse is high for exactly the one clock that follows that pre_tick.
- R6: frag_sel steps 0,1,2,3 and wraps. Each slot lasts SLOT_CYCLES clocks, and frag_take is high in the last clock of a slot, when frag_data is captured. Slot 0 carries word bits 3:0, slot 1 bits 7:4 and slot 2 bits 11:8. Slot 3 carries bits 13:12 on frag_data[1:0], and frag_data[3:2] are ignored.
- R7: A word that completes in slot 3 is applied only at a later cycle boundary. If its capture falls on the same clock as a boundary, that boundary reloads the previously stored word.
- R8: While hold_word is high at the end of slot 3, the completed word is not stored, and the division ratio stays as before.
- R9: While freeze_mux is high, frag_take stays low and frag_sel holds, so no fragment is captured.
- R10: During reset, frag_sel, frag_take, mod_ctl and div_pulse are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it is also the prescaler input clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_tick | input | 1 | One-clock pulse per prescaler output |
| frag_data | input | 4 | Fragment data for the slot shown on frag_sel |
| shift_n | input | 1 | Low selects the upper span (+5120) |
| hold_word | input | 1 | High blocks storing of a completed word |
| freeze_mux | input | 1 | High halts the fragment sequencer |
| frag_sel | output | 2 | Fragment slot currently requested |
| frag_take | output | 1 | Capture strobe, last clock of a slot |
| mod_ctl | output | 1 | Prescaler modulus: 1 = divide by 41 |
| div_pulse | output | 1 | One-clock pulse per completed division cycle |

## Verification
A new word's store at the end of slot 3 and a division-cycle boundary can happen on the same clock. The bench forces this overlap by driving pre_tick by hand. It first issues all but one prescaler pulse of a cycle, then issues the final pulse in exactly the clock where frag_take is high with frag_sel at 3. The overlap is judged by counting pre_tick pulses, and pulses with mod_ctl high, in the next two cycles: the first must still carry the old word and the second the new one.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

    localparam int SWAL_W     = 6;
    localparam int MAIN_W     = 8;
    localparam int WORD_W     = SWAL_W + MAIN_W;
    localparam int NIB_W      = 4;
    localparam int FRAG_N     = (WORD_W + NIB_W - 1) / NIB_W;
    localparam int SEL_W      = $clog2(FRAG_N);
    localparam int PRE_MOD    = 40;
    localparam int BASE_NORM  = 40;
    localparam int BASE_SHIFT = BASE_NORM + 128;
    localparam int CNT_W      = $clog2(BASE_SHIFT + (1 << MAIN_W));
    localparam int SWAL_LIMIT = PRE_MOD - 1;

    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [SWAL_W-1:0] swal;
    } div_word_t;

    typedef struct packed {
        logic [CNT_W-1:0]  cycles;
        logic [SWAL_W-1:0] swal;
    } div_load_t;

    function automatic div_load_t make_load(div_word_t w, logic shifted);
        div_load_t r;
        r.cycles = CNT_W'(w.main) + (shifted ? CNT_W'(BASE_SHIFT) : CNT_W'(BASE_NORM));
        r.swal   = (w.swal > SWAL_W'(SWAL_LIMIT)) ? SWAL_W'(SWAL_LIMIT) : w.swal;
        return r;
    endfunction

endpackage

// File: rtl/dmd_frag_seq.sv
module dmd_frag_seq
    import dmd_pkg::*;
#(
    parameter int SLOT_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    output logic [SEL_W-1:0] sel,
    output logic             take
);
    localparam int SLOT_W = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;

    logic [SLOT_W-1:0] slot_q;

    assign take = !freeze && (slot_q == SLOT_W'(SLOT_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            sel    <= '0;
        end else if (!freeze) begin
            if (take) begin
                slot_q <= '0;
                if (sel == SEL_W'(FRAG_N - 1)) begin
                    sel <= '0;
                end else begin
                    sel <= sel + 1'b1;
                end
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmd_word_asm.sv
module dmd_word_asm
    import dmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [SEL_W-1:0] sel,
    input  logic [NIB_W-1:0] data,
    input  logic             hold,
    output div_word_t        stored
);
    logic [WORD_W-1:0] asm_q;
    logic [WORD_W-1:0] asm_next;
    logic              finish;

    for (genvar f = 0; f < FRAG_N; f++) begin : g_frag
        localparam int LO = f * NIB_W;
        localparam int HI = ((LO + NIB_W) < WORD_W) ? (LO + NIB_W - 1) : (WORD_W - 1);
        localparam int FW = HI - LO + 1;
        assign asm_next[HI:LO] = (take && (sel == SEL_W'(f))) ? data[FW-1:0] : asm_q[HI:LO];
    end

    assign finish = take && (sel == SEL_W'(FRAG_N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            asm_q  <= '0;
            stored <= '0;
        end else begin
            asm_q <= asm_next;
            if (finish && !hold) begin
                stored <= div_word_t'(asm_next);
            end
        end
    end

endmodule

// File: rtl/dmd_swallow_core.sv
module dmd_swallow_core
    import dmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  div_word_t stored,
    input  logic      shift_n,
    output logic      mod_ctl,
    output logic      div_pulse
);
    logic [CNT_W-1:0]  main_q;
    logic [SWAL_W-1:0] swal_q;
    div_load_t         load;
    logic              at_end;

    assign load   = make_load(stored, !shift_n);
    assign at_end = tick && (main_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q    <= CNT_W'(BASE_NORM);
            swal_q    <= '0;
            mod_ctl   <= 1'b0;
            div_pulse <= 1'b0;
        end else begin
            div_pulse <= 1'b0;
            if (at_end) begin
                main_q    <= load.cycles;
                swal_q    <= load.swal;
                mod_ctl   <= (load.swal != '0);
                div_pulse <= 1'b1;
            end else if (tick) begin
                main_q <= main_q - 1'b1;
                if (swal_q != '0) begin
                    swal_q  <= swal_q - 1'b1;
                    mod_ctl <= (swal_q != SWAL_W'(1));
                end
            end
        end
    end

endmodule

// File: rtl/dmd_prog_divider.sv
module dmd_prog_divider
    import dmd_pkg::*;
#(
    parameter int SLOT_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pre_tick,
    input  logic [NIB_W-1:0] frag_data,
    input  logic             shift_n,
    input  logic             hold_word,
    input  logic             freeze_mux,
    output logic [SEL_W-1:0] frag_sel,
    output logic             frag_take,
    output logic             mod_ctl,
    output logic             div_pulse
);
    div_word_t stored;

    dmd_frag_seq #(.SLOT_CYCLES(SLOT_CYCLES)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .freeze (freeze_mux),
        .sel    (frag_sel),
        .take   (frag_take)
    );

    dmd_word_asm u_asm (
        .clk    (clk),
        .rst    (rst),
        .take   (frag_take),
        .sel    (frag_sel),
        .data   (frag_data),
        .hold   (hold_word),
        .stored (stored)
    );

    dmd_swallow_core u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (pre_tick),
        .stored    (stored),
        .shift_n   (shift_n),
        .mod_ctl   (mod_ctl),
        .div_pulse (div_pulse)
    );

endmodule

// File: rtl/dmd_prog_divider_chk.sv
module dmd_prog_divider_chk
    import dmd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pre_tick,
    input logic             freeze_mux,
    input logic [SEL_W-1:0] frag_sel,
    input logic             frag_take,
    input logic             mod_ctl,
    input logic             div_pulse
);
    // R5: output pulse lasts one clock
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R5: output pulse follows a prescaler pulse
    assert_pulse_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> $past(pre_tick));

    // R4: modulus only moves after a prescaler pulse
    assert_mod_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !pre_tick |=> $stable(mod_ctl));

    // R4: modulus only rises at a cycle reload
    assert_mod_rise_at_reload_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_ctl) |-> div_pulse);

    // R6: slot index advances by one after each capture
    assert_sel_step_R6: assert property (@(posedge clk) disable iff (rst)
        frag_take |=> (frag_sel == SEL_W'($past(frag_sel) + 1'b1)));

    // R9: no capture while frozen
    assert_no_take_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        freeze_mux |-> !frag_take);

    // R9: slot index holds while frozen
    assert_sel_hold_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        freeze_mux |=> $stable(frag_sel));

endmodule

bind dmd_prog_divider dmd_prog_divider_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .pre_tick   (pre_tick),
    .freeze_mux (freeze_mux),
    .frag_sel   (frag_sel),
    .frag_take  (frag_take),
    .mod_ctl    (mod_ctl),
    .div_pulse  (div_pulse)
);

// File: tb/test_dmd_prog_divider.sv
module test_dmd_prog_divider;

    localparam int SLOT   = 64;
    localparam int MAXCYC = 195000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_tick;
    logic [3:0] frag_data;
    logic       shift_n    = 1'b1;
    logic       hold_word  = 1'b0;
    logic       freeze_mux = 1'b0;
    logic [1:0] frag_sel;
    logic       frag_take;
    logic       mod_ctl;
    logic       div_pulse;

    logic        manual     = 1'b0;
    logic        man_tick   = 1'b0;
    logic        model_tick;
    int          pc;
    logic [13:0] bench_word = '0;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int    n;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    // behavioural 40/41 prescaler, modulus sampled late in its period
    always @(posedge clk) begin
        if (rst) begin
            pc         <= 0;
            model_tick <= 1'b0;
        end else if ((pc == 39 && !mod_ctl) || pc == 40) begin
            pc         <= 0;
            model_tick <= 1'b1;
        end else begin
            pc         <= pc + 1;
            model_tick <= 1'b0;
        end
    end

    assign pre_tick = manual ? man_tick : model_tick;

    always_comb begin
        case (frag_sel)
            2'd0:    frag_data = bench_word[3:0];
            2'd1:    frag_data = bench_word[7:4];
            2'd2:    frag_data = bench_word[11:8];
            default: frag_data = {2'b11, bench_word[13:12]};
        endcase
    end

    dmd_prog_divider #(.SLOT_CYCLES(SLOT)) i_dmd_prog_divider (
        .clk        (clk),
        .rst        (rst),
        .pre_tick   (pre_tick),
        .frag_data  (frag_data),
        .shift_n    (shift_n),
        .hold_word  (hold_word),
        .freeze_mux (freeze_mux),
        .frag_sel   (frag_sel),
        .frag_take  (frag_take),
        .mod_ctl    (mod_ctl),
        .div_pulse  (div_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int exp_n(input int m, input int a, input bit sh);
        int base = sh ? 40 : 168;
        int aa   = (a > 39) ? 39 : a;
        return 40 * (m + base) + aa;
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // monitor: measures clocks between output pulses, pops expectations
    exp_t mon_e;
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                cnt = 0;
            end else if (div_pulse) begin
                if (!manual && sb.size() > 0) begin
                    mon_e = sb.pop_front();
                    check(cnt + 1 == mon_e.n, mon_e.tag, cnt + 1, mon_e.n);
                end
                cnt = 0;
            end else begin
                cnt++;
            end
        end
    end

    task automatic wait_xfer();
        do @(negedge clk); while (!(frag_take && frag_sel == 2'd3));
        @(negedge clk);
    endtask

    task automatic auto_case(input int m, input int a, input bit sh, input string tag);
        bench_word = {m[7:0], a[5:0]};
        shift_n    = sh;
        wait_xfer();
        wait_xfer();
        do @(negedge clk); while (!div_pulse);
        @(negedge clk);
        sb.push_back('{exp_n(m, a, sh), tag});
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic run_cycle(output int k, output int a);
        bit done = 0;
        k = 0;
        a = 0;
        while (!done) begin
            @(negedge clk);
            man_tick = 1'b1;
            k++;
            if (mod_ctl) a++;
            @(negedge clk);
            man_tick = 1'b0;
            if (div_pulse) done = 1;
        end
    endtask

    task automatic measure_manual(input int m, input int a, input bit sh, input string tag);
        int k, ac;
        int base = sh ? 40 : 168;
        int aa   = (a > 39) ? 39 : a;
        run_cycle(k, ac);
        run_cycle(k, ac);
        check(k == m + base, {tag, " ticks"}, k, m + base);
        check(ac == aa, {tag, " mod-high ticks"}, ac, aa);
    endtask

    task automatic manual_case(input int m, input int a, input bit sh, input string tag);
        bench_word = {m[7:0], a[5:0]};
        shift_n    = sh;
        wait_xfer();
        wait_xfer();
        measure_manual(m, a, sh, tag);
    endtask

    initial begin
        repeat (MAXCYC) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", MAXCYC, 0);
        finish_run();
    end

    initial begin
        int k, ac, s0, cnt;
        bit ok;

        // R10: reset state
        repeat (3) @(negedge clk);
        check(frag_sel == 2'd0, "R10 frag_sel", frag_sel, 0);
        check(frag_take == 1'b0, "R10 frag_take", frag_take, 0);
        check(mod_ctl == 1'b0, "R10 mod_ctl", mod_ctl, 0);
        check(div_pulse == 1'b0, "R10 div_pulse", div_pulse, 0);
        rst = 1'b0;

        // R6: slot length and stepping
        for (int i = 0; i < 4; i++) begin
            do @(negedge clk); while (!frag_take);
            s0  = frag_sel;
            cnt = 0;
            do begin @(negedge clk); cnt++; end while (!frag_take);
            check(cnt == SLOT, "R6 slot length", cnt, SLOT);
            check(frag_sel == 2'((s0 + 1) % 4), "R6 slot order", frag_sel, (s0 + 1) % 4);
        end

        // R1 / R2 / R3 through the prescaler model
        auto_case(0, 0, 1'b1, "R1 minimum 1600");
        auto_case(10, 63, 1'b1, "R3 clamp 2039");
        for (int i = 0; i < 3; i++) begin
            auto_case($urandom_range(0, 15), $urandom_range(0, 39), 1'(i % 2), "R1 R2 random word");
        end
        auto_case(0, 0, 1'b0, "R2 shifted minimum 6720");
        auto_case(255, 39, 1'b1, "R1 maximum 11839");
        auto_case(255, 39, 1'b0, "R2 shifted maximum 16959");

        // manual prescaler pulses
        @(negedge clk);
        manual   = 1'b1;
        man_tick = 1'b0;
        shift_n  = 1'b1;

        manual_case(0, 50, 1'b1, "R3 R4 clamp manual");
        manual_case(3, 2, 1'b1, "R4 R5 base word");

        // R8: hold blocks storage
        hold_word  = 1'b1;
        bench_word = {8'd6, 6'd9};
        wait_xfer();
        wait_xfer();
        measure_manual(3, 2, 1'b1, "R8 held word");
        hold_word = 1'b0;
        wait_xfer();
        wait_xfer();
        measure_manual(6, 9, 1'b1, "R8 released word");

        // R9: freeze halts capture
        @(negedge clk);
        freeze_mux = 1'b1;
        s0 = frag_sel;
        bench_word = {8'd1, 6'd4};
        ok = 1;
        repeat (3 * SLOT) begin
            @(negedge clk);
            if (frag_take || frag_sel != 2'(s0)) ok = 0;
        end
        check(ok, "R9 sequencer frozen", frag_sel, s0);
        measure_manual(6, 9, 1'b1, "R9 frozen word");
        freeze_mux = 1'b0;
        wait_xfer();
        wait_xfer();
        measure_manual(1, 4, 1'b1, "R9 unfrozen word");

        // R7: store and boundary on the same clock
        manual_case(0, 5, 1'b1, "R7 old word");
        do @(negedge clk); while (!(frag_take && frag_sel == 2'd3));
        @(negedge clk);
        bench_word = {8'd2, 6'd7};
        for (int i = 0; i < 39; i++) begin
            man_tick = 1'b1;
            @(negedge clk);
            man_tick = 1'b0;
            @(negedge clk);
        end
        while (!(frag_take && frag_sel == 2'd3)) @(negedge clk);
        man_tick = 1'b1;
        @(negedge clk);
        man_tick = 1'b0;
        check(div_pulse == 1'b1, "R7 boundary on store clock", div_pulse, 1);
        run_cycle(k, ac);
        check(k == 40, "R7 cycle after overlap keeps old ticks", k, 40);
        check(ac == 5, "R7 cycle after overlap keeps old swallow", ac, 5);
        run_cycle(k, ac);
        check(k == 42, "R7 following cycle new ticks", k, 42);
        check(ac == 7, "R7 following cycle new swallow", ac, 7);

        finish_run();
    end

endmodule